// File: doc/BRIEF.md
# Timer Interrupt Flag Controller

This block gathers expiry events from eight down-counting timers into one interrupt line. Each timer supplies a single level that is high while its count is nonzero. The block watches for that level falling from one to zero and records each such event in a sticky flag bit. A per-flag mask then decides whether the flag may raise the interrupt request. Four status-alarm flags arrive already latched from elsewhere, and a separate 4-bit mask gates them into the same request line.

Software uses a small synchronous register port. Reads are combinational from the address. Writes take effect on the clock edge on which the write strobe is high. Software clears a flag by writing a zero to its bit position. Writing a one to a flag bit does nothing. The interrupt output is registered and active-high.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset, the flag register reads 0x00, the timer mask reads 0xFF, the alarm mask reads 0x0F and `irq` is 0.
- R2: A flag bit is set on the clock edge at which its timer level was high on the previous edge and is low now. The bit then stays set until software clears it. The flag bit order from 7 down to 0 is: general timer 4, general timer 3, SNR alarm timer, meter timer, startup timers 4, 3, 2 and 1.
- R3: A write to address 0 clears each flag bit whose written data bit is 0. Flag bits written with 1 keep their value.
- R4: A timer level that stays at zero never sets a flag again after it has been cleared. Only a new high-to-low change of the level sets the flag.
- R5: `irq` is registered. One edge after the state changes, `irq` is 1 if any flag or alarm input has its mask bit at 0. A mask bit of 1 blocks its source.
- R6: Clearing an unmasked flag drops `irq` only when no other unmasked flag or alarm remains set.
- R7: The alarm mask at address 2 holds bits 3..0, which gate alarm inputs 3..0. Bits 7..4 read as 0, and writes to them are ignored.
- R8: If a flag's high-to-low event and a write-zero clear of that flag fall on the same edge, the flag ends up set.
- R9: The address map is: 0 for the flags, 1 for the timer mask (bit i gates flag i), 2 for the alarm mask, and 3 for an unused location that reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer_nz | input | 8 | One level per timer, high while its count is nonzero |
| alarm_flags | input | 4 | Status-alarm flags, already latched upstream |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request, registered, active-high |

## Verification
The bound checker watches several rules on every cycle:
- every detected high-to-low event leaves its flag set one edge later, including when a clear hits the same edge;
- a flag rises only after an event;
- set flags survive any cycle without a flag write;
- a flag write never clears a bit written with one;
- `irq` follows the masked sources one edge later;
- the unused read bits stay zero.

Some behaviours only the bench scenarios can show:
- the reset values;
- the bit positions of the flags;
- that a steady zero level does not re-arm a cleared flag;
- that clearing one of two unmasked flags keeps the interrupt raised, in the order a driver would really do it.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;

   localparam int unsigned REG_ADDR_W = 2;

   typedef enum logic [REG_ADDR_W-1:0] {
      RA_FLAGS = 2'd0,
      RA_TMASK = 2'd1,
      RA_AMASK = 2'd2,
      RA_NONE  = 2'd3
   } reg_addr_e;

endpackage

// File: rtl/tmr_fall_detect.sv
module tmr_fall_detect #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] level_i,
   output logic [N-1:0] prev_o,
   output logic [N-1:0] fall_o
);

   logic [N-1:0] prev_q;

   // Previous sample resets low so a timer idling at zero raises no event.
   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level_i;
   end

   assign fall_o = prev_q & ~level_i;
   assign prev_o = prev_q;

endmodule

// File: rtl/tmr_sticky_flags.sv
module tmr_sticky_flags #(
   parameter int unsigned N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_en_i,
   input  logic [N-1:0] keep_i,
   output logic [N-1:0] flags_o
);

   logic [N-1:0] flag_q;

   for (genvar i = 0; i < N; i++) begin : g_bit
      // A set event outranks a clear on the same edge.
      always_ff @(posedge clk) begin
         if (!rst_n)                       flag_q[i] <= 1'b0;
         else if (set_i[i])                flag_q[i] <= 1'b1;
         else if (clr_en_i && !keep_i[i])  flag_q[i] <= 1'b0;
      end
   end

   assign flags_o = flag_q;

endmodule

// File: rtl/tmr_mask_reg.sv
module tmr_mask_reg #(
   parameter int unsigned W      = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [W-1:0]      wdata_i,
   output logic [W-1:0]      mask_o,
   output logic [DATA_W-1:0] rd_o
);

   localparam int unsigned PAD_W = DATA_W - W;

   logic [W-1:0] mask_q;

   // Every source is blocked out of reset.
   always_ff @(posedge clk) begin
      if (!rst_n)    mask_q <= '1;
      else if (we_i) mask_q <= wdata_i;
   end

   assign mask_o = mask_q;

   if (PAD_W > 0) begin : g_pad
      assign rd_o = {{PAD_W{1'b0}}, mask_q};
   end else begin : g_full
      assign rd_o = mask_q;
   end

endmodule

// File: rtl/tmr_irq_merge.sv
module tmr_irq_merge #(
   parameter int unsigned NT = 8,
   parameter int unsigned NA = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NT-1:0] flags_i,
   input  logic [NT-1:0] tmask_i,
   input  logic [NA-1:0] alarms_i,
   input  logic [NA-1:0] amask_i,
   output logic          irq_o
);

   logic pend_tmr, pend_alm, irq_q;

   assign pend_tmr = |(flags_i & ~tmask_i);
   assign pend_alm = |(alarms_i & ~amask_i);

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= pend_tmr | pend_alm;
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
   parameter int unsigned NUM_TIMERS = 8,
   parameter int unsigned NUM_ALARMS = 4,
   parameter int unsigned DATA_W     = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_TIMERS-1:0]               timer_nz,
   input  logic [NUM_ALARMS-1:0]               alarm_flags,
   input  logic [tmr_irq_pkg::REG_ADDR_W-1:0]  reg_addr,
   input  logic                                reg_wr,
   input  logic [DATA_W-1:0]                   reg_wdata,
   output logic [DATA_W-1:0]                   reg_rdata,
   output logic                                irq
);
   import tmr_irq_pkg::*;

   localparam int unsigned FLAG_PAD = DATA_W - NUM_TIMERS;

   if (NUM_TIMERS > DATA_W || NUM_TIMERS == 0) begin : g_bad_timers
      $error("NUM_TIMERS must be between 1 and DATA_W");
   end
   if (NUM_ALARMS > DATA_W || NUM_ALARMS == 0) begin : g_bad_alarms
      $error("NUM_ALARMS must be between 1 and DATA_W");
   end

   logic [NUM_TIMERS-1:0] level_prev, fall_evt, flags_q, tmask_q;
   logic [NUM_ALARMS-1:0] amask_q;
   logic [DATA_W-1:0]     flags_rd, tmask_rd, amask_rd;
   logic                  wr_flags, wr_tmask, wr_amask;

   assign wr_flags = reg_wr && (reg_addr == RA_FLAGS);
   assign wr_tmask = reg_wr && (reg_addr == RA_TMASK);
   assign wr_amask = reg_wr && (reg_addr == RA_AMASK);

   tmr_fall_detect #(.N(NUM_TIMERS)) u_fall (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (timer_nz),
      .prev_o  (level_prev),
      .fall_o  (fall_evt)
   );

   tmr_sticky_flags #(.N(NUM_TIMERS)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (fall_evt),
      .clr_en_i (wr_flags),
      .keep_i   (reg_wdata[NUM_TIMERS-1:0]),
      .flags_o  (flags_q)
   );

   tmr_mask_reg #(.W(NUM_TIMERS), .DATA_W(DATA_W)) u_tmask (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (wr_tmask),
      .wdata_i (reg_wdata[NUM_TIMERS-1:0]),
      .mask_o  (tmask_q),
      .rd_o    (tmask_rd)
   );

   tmr_mask_reg #(.W(NUM_ALARMS), .DATA_W(DATA_W)) u_amask (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (wr_amask),
      .wdata_i (reg_wdata[NUM_ALARMS-1:0]),
      .mask_o  (amask_q),
      .rd_o    (amask_rd)
   );

   tmr_irq_merge #(.NT(NUM_TIMERS), .NA(NUM_ALARMS)) u_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .flags_i  (flags_q),
      .tmask_i  (tmask_q),
      .alarms_i (alarm_flags),
      .amask_i  (amask_q),
      .irq_o    (irq)
   );

   if (FLAG_PAD > 0) begin : g_flag_pad
      assign flags_rd = {{FLAG_PAD{1'b0}}, flags_q};
   end else begin : g_flag_full
      assign flags_rd = flags_q;
   end

   always_comb begin
      unique case (reg_addr)
         RA_FLAGS: reg_rdata = flags_rd;
         RA_TMASK: reg_rdata = tmask_rd;
         RA_AMASK: reg_rdata = amask_rd;
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
module tmr_irq_ctrl_chk #(
   parameter int unsigned NUM_TIMERS = 8,
   parameter int unsigned NUM_ALARMS = 4,
   parameter int unsigned DATA_W     = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_TIMERS-1:0] timer_nz,
   input logic [NUM_ALARMS-1:0] alarm_flags,
   input logic [1:0]            reg_addr,
   input logic                  reg_wr,
   input logic [DATA_W-1:0]     reg_wdata,
   input logic [DATA_W-1:0]     reg_rdata,
   input logic                  irq,
   input logic [NUM_TIMERS-1:0] level_prev,
   input logic [NUM_TIMERS-1:0] flags_q,
   input logic [NUM_TIMERS-1:0] tmask_q,
   input logic [NUM_ALARMS-1:0] amask_q
);

   logic [NUM_TIMERS-1:0] evt;
   logic                  fwr;
   assign evt = level_prev & ~timer_nz;
   assign fwr = reg_wr && (reg_addr == 2'd0);

   // R2: every detected event leaves its flag set on the next edge
   p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((flags_q & $past(evt)) == $past(evt)));

   // R2: without a flag write, set flags stay set
   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !fwr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

   // R3: a flag written with one is not cleared
   p_write_one_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fwr |=> ((($past(flags_q) & ~flags_q) & $past(reg_wdata[NUM_TIMERS-1:0])) == '0));

   // R4: a flag only rises after a detected event
   p_no_spurious_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((flags_q & ~$past(flags_q) & ~$past(evt)) == '0));

   // R8: a set event wins over a same-edge clear
   p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fwr && |(evt & ~reg_wdata[NUM_TIMERS-1:0])) |=> ((flags_q & $past(evt)) == $past(evt)));

   // R5: any unmasked source raises irq one edge later
   p_irq_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flags_q & ~tmask_q) || |(alarm_flags & ~amask_q)) |=> irq);

   // R6: with no unmasked source left, irq drops one edge later
   p_irq_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (((flags_q & ~tmask_q) == '0) && ((alarm_flags & ~amask_q) == '0)) |=> !irq);

   // R9: the unused address reads zero
   p_none_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd3) |-> (reg_rdata == '0));

   if (NUM_ALARMS < DATA_W) begin : g_pad_chk
      // R7: unused alarm-mask bits read zero
      p_amask_pad_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_addr == 2'd2) |-> (reg_rdata[DATA_W-1:NUM_ALARMS] == '0));
   end

endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk #(
   .NUM_TIMERS (NUM_TIMERS),
   .NUM_ALARMS (NUM_ALARMS),
   .DATA_W     (DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .timer_nz    (timer_nz),
   .alarm_flags (alarm_flags),
   .reg_addr    (reg_addr),
   .reg_wr      (reg_wr),
   .reg_wdata   (reg_wdata),
   .reg_rdata   (reg_rdata),
   .irq         (irq),
   .level_prev  (level_prev),
   .flags_q     (flags_q),
   .tmask_q     (tmask_q),
   .amask_q     (amask_q)
);

// File: tb/tmr_irq_ctrl_tb.sv
module tmr_irq_ctrl_tb;

   typedef struct {
      logic [7:0] rd;
      logic       irq;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] timer_nz = '0;
   logic [3:0] alarm_flags = '0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;
   exp_t sb[$];

   logic [7:0] m_flags = '0, m_tmask = 8'hFF, m_prev = '0;
   logic [3:0] m_amask = 4'hF;

   always #10 clk = ~clk;

   tmr_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .timer_nz(timer_nz), .alarm_flags(alarm_flags),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   function automatic logic model_irq();
      return (|(m_flags & ~m_tmask)) | (|(alarm_flags & ~m_amask));
   endfunction

   // One bus/timer cycle; the model tracks the edge that follows.
   task automatic op(input bit wr, input logic [1:0] a, input logic [7:0] d,
                     input logic [7:0] nz);
      logic [7:0] fall;
      @(negedge clk);
      reg_wr = wr; reg_addr = a; reg_wdata = d; timer_nz = nz;
      fall = m_prev & ~nz;
      if (wr && a == 2'd0) m_flags = (m_flags & d) | fall;
      else                 m_flags = m_flags | fall;
      if (wr && a == 2'd1) m_tmask = d;
      if (wr && a == 2'd2) m_amask = d[3:0];
      m_prev = nz;
   endtask

   task automatic tick(input logic [7:0] nz);
      op(1'b0, 2'd3, 8'h00, nz);
   endtask

   task automatic set_alarm(input logic [3:0] al);
      @(negedge clk);
      reg_wr = 1'b0; alarm_flags = al;
   endtask

   // Driver: push the value expected after the coming edge.
   task automatic chk(input logic [1:0] a, input logic [7:0] e, input string tag);
      exp_t it;
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = a;
      it.rd = e; it.irq = model_irq(); it.tag = tag;
      sb.push_back(it);
   endtask

   // Monitor: compare away from the clock edge.
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            n_run++;
            if (reg_rdata !== it.rd || irq !== it.irq) begin
               n_fail++;
               $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                        it.tag, reg_rdata, irq, it.rd, it.irq);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 / R9: reset values through the address map
      chk(2'd0, 8'h00, "R1 flags");
      chk(2'd1, 8'hFF, "R1 tmask");
      chk(2'd2, 8'h0F, "R1 amask");
      chk(2'd3, 8'h00, "R9 none");
      // R2: falls on bits 7 and 0
      tick(8'hFF);
      tick(8'h7E);
      chk(2'd0, 8'h81, "R2 fall sets bits 7,0");
      tick(8'h7E);
      tick(8'h7E);
      chk(2'd0, 8'h81, "R2 sticky");
      // R5: masked flags keep irq low, unmasking raises it
      chk(2'd1, 8'hFF, "R5 masked irq low");
      op(1'b1, 2'd1, 8'hFE, 8'h7E);
      chk(2'd1, 8'hFE, "R5 unmask bit0 irq high");
      // R3: writing ones leaves flags alone
      op(1'b1, 2'd0, 8'hFF, 8'h7E);
      chk(2'd0, 8'h81, "R3 write ones no effect");
      // R6: two unmasked flags, clear one then the other
      op(1'b1, 2'd1, 8'h7E, 8'h7E);
      op(1'b1, 2'd0, 8'hFE, 8'h7E);
      chk(2'd0, 8'h80, "R6 other flag keeps irq");
      op(1'b1, 2'd0, 8'h7F, 8'h7E);
      chk(2'd0, 8'h00, "R6 last clear drops irq");
      // R4: steady zero does not re-arm; a new fall does
      tick(8'h7E);
      tick(8'h7E);
      chk(2'd0, 8'h00, "R4 steady zero");
      tick(8'h7F);
      tick(8'h7E);
      chk(2'd0, 8'h01, "R4 new fall re-arms");
      // R8: bit1 falls on the same edge as a clear-all write
      op(1'b1, 2'd0, 8'h00, 8'h7C);
      chk(2'd0, 8'h02, "R8 set beats clear");
      // R7: upper alarm-mask bits ignored; alarm gating
      op(1'b1, 2'd1, 8'hFF, 8'h7C);
      op(1'b1, 2'd2, 8'hF5, 8'h7C);
      chk(2'd2, 8'h05, "R7 amask upper bits");
      set_alarm(4'h2);
      chk(2'd2, 8'h05, "R7 open alarm raises irq");
      set_alarm(4'h1);
      chk(2'd2, 8'h05, "R7 masked alarm irq low");
      // R9: writes to the unused address change nothing
      op(1'b1, 2'd3, 8'hFF, 8'h7C);
      chk(2'd3, 8'h00, "R9 unused reads zero");
      chk(2'd0, 8'h02, "R9 flags untouched");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule